// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a two-channel PCM stream carried on three wires (a bit clock, a word clock that marks the channel, and serial data) and turns it into parallel 24-bit left and right samples. Each completed stereo pair is presented with a single-cycle strobe. All three stream wires, and the master clock, are sampled in the block's own system clock domain. They pass through a short synchronizer before any edge is detected, so the system clock must run at least four times faster than the fastest stream clock.

A static 3-bit format code selects the framing. The options are standard I2S framing, 24-bit left-justified framing, and right-justified framing. Right-justified framing comes with MSB-first words of 16, 18, 20 or 24 bits, or with 24-bit LSB-first words. Whatever the framing, one shift register collects the bits and one alignment stage turns the finished word into a 24-bit sample. In that sample the sign bit sits in bit 23, and any bits missing from a shorter word are zero-filled below it.

A separate monitor counts master clock rising edges over each word-clock period. It raises a flag when the count is one of the supported master-clock-to-sample-rate ratios.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is held, and until the first stereo pair completes, `left_sample` and `right_sample` are zero and `sample_valid` is low. `ratio_ok` is low until a full word-clock period has been measured.
- R2: With format code 0 (I2S), the word clock low marks the left channel. The sample MSB arrives on the second bit-clock rising edge after a word-clock change. The first 24 bits of the word form the sample, MSB first.
- R3: With format code 1 (left-justified, 24-bit), the word clock high marks the left channel. The MSB arrives on the first bit-clock rising edge after a word-clock change. The first 24 bits form the sample.
- R4: With format codes 3, 4, 5 and 6 (right-justified, MSB first, 16, 18, 20 and 24 bits), the word clock high marks the left channel. Only the final N bits before the next word-clock change are kept. They are placed with their MSB at sample bit 23, zeros fill the bits below, and earlier bits in the slot are ignored.
- R5: With format code 2 (right-justified, LSB first, 24-bit), the word clock high marks the left channel. The final 24 bits before the word-clock change are kept, with the last bit taken as the sample MSB (bit 23) and the earliest of the 24 as bit 0.
- R6: With format code 7 (reserved), every strobed pair is zero in both channels.
- R7: `sample_valid` pulses high for exactly one system clock once per stereo frame. It rises after the right-channel word completes, that is, at the word-clock change that ends the right slot. `left_sample` and `right_sample` update together in that cycle.
- R8: `ratio_ok` reflects the most recent word-clock period. Such a period runs from one rising edge of the word clock to the next. The flag is high when the master clock rose exactly 256, 384, 512 or 768 times in that period, and low for any other count.
- R9: Between strobes, `left_sample` and `right_sample` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| fmt_sel | input | 3 | Static framing code (0..7, see R2 to R6) |
| mck | input | 1 | Master clock, asynchronous |
| bck | input | 1 | Bit clock, asynchronous |
| lrck | input | 1 | Word clock marking the channel, asynchronous |
| sdin | input | 1 | Serial audio data, valid on bit-clock rising edges |
| left_sample | output | 24 | Left channel sample, MSB-aligned |
| right_sample | output | 24 | Right channel sample, MSB-aligned |
| sample_valid | output | 1 | One-cycle strobe for a new stereo pair |
| ratio_ok | output | 1 | Master clock ratio is a supported value |

## Verification
A wrong bit count, or a wrong channel polarity, shows up at the first strobe after the fault. The outputs then carry a sample that is bit-shifted or on the wrong side, or the strobe arrives one word late, and the per-format expected values catch either case at once. Junk bits ahead of a right-justified word would leak into the high bits of the very next sample if the alignment slipped. A broken ratio counter shows on `ratio_ok` within two word-clock periods of a change in master clock rate.

// File: rtl/serial_audio_rx_pkg.sv
package serial_audio_rx_pkg;

    typedef enum logic [2:0] {
        FMT_I2S       = 3'd0,
        FMT_LJ24      = 3'd1,
        FMT_RJ24_LSBF = 3'd2,
        FMT_RJ16      = 3'd3,
        FMT_RJ18      = 3'd4,
        FMT_RJ20      = 3'd5,
        FMT_RJ24      = 3'd6,
        FMT_OFF       = 3'd7
    } fmt_e;

endpackage

// File: rtl/serial_audio_rx_sync.sv
module serial_audio_rx_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [WIDTH-1:0] rise
);
    typedef logic [STAGES:0][WIDTH-1:0] pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int i = 1; i <= STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];
    assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/serial_audio_rx_ratio.sv
module serial_audio_rx_ratio #(
    parameter int CNT_W   = 10,
    parameter int RATIO_A = 256,
    parameter int RATIO_B = 384,
    parameter int RATIO_C = 512,
    parameter int RATIO_D = 768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mck_rise,
    input  logic frame_rise,
    output logic ratio_ok
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             seen;
        logic             ok;
    } ratio_st_t;

    ratio_st_t st_d, st_q;
    logic      hit;

    always_comb begin
        hit = (st_q.cnt == CNT_W'(RATIO_A)) || (st_q.cnt == CNT_W'(RATIO_B)) ||
              (st_q.cnt == CNT_W'(RATIO_C)) || (st_q.cnt == CNT_W'(RATIO_D));
        st_d = st_q;
        if (frame_rise) begin
            st_d.ok   = st_q.seen && hit;
            st_d.seen = 1'b1;
            st_d.cnt  = mck_rise ? CNT_W'(1) : '0;
        end else if (mck_rise && st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ratio_ok = st_q.ok;
endmodule

// File: rtl/serial_audio_rx_align.sv
module serial_audio_rx_align
    import serial_audio_rx_pkg::*;
#(
    parameter int SLOT_W   = 32,
    parameter int SAMPLE_W = 24,
    parameter int CNT_W    = $clog2(SLOT_W + 1)
) (
    input  fmt_e                fmt,
    input  logic [SLOT_W-1:0]   word,
    input  logic [CNT_W-1:0]    nbits,
    output logic [SAMPLE_W-1:0] sample
);
    logic [SLOT_W-1:0]   msb_left;
    logic [CNT_W-1:0]    lshift;
    logic [SAMPLE_W-1:0] tail;
    logic [SAMPLE_W-1:0] reversed;

    always_comb begin
        lshift   = CNT_W'(SLOT_W) - nbits;
        msb_left = word << lshift;
        tail     = word[SAMPLE_W-1:0];
        for (int i = 0; i < SAMPLE_W; i++) begin
            reversed[i] = word[SAMPLE_W-1-i];
        end
        case (fmt)
            FMT_I2S, FMT_LJ24: sample = msb_left[SLOT_W-1 -: SAMPLE_W];
            FMT_RJ24_LSBF:     sample = reversed;
            FMT_RJ16:          sample = tail << (SAMPLE_W - 16);
            FMT_RJ18:          sample = tail << (SAMPLE_W - 18);
            FMT_RJ20:          sample = tail << (SAMPLE_W - 20);
            FMT_RJ24:          sample = tail;
            default:           sample = '0;
        endcase
    end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import serial_audio_rx_pkg::*;
#(
    parameter int SLOT_W      = 32,
    parameter int SAMPLE_W    = 24,
    parameter int SYNC_STAGES = 2,
    parameter int RATIO_CNT_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          fmt_sel,
    input  logic                mck,
    input  logic                bck,
    input  logic                lrck,
    input  logic                sdin,
    output logic [SAMPLE_W-1:0] left_sample,
    output logic [SAMPLE_W-1:0] right_sample,
    output logic                sample_valid,
    output logic                ratio_ok
);
    localparam int CNT_W = $clog2(SLOT_W + 1);

    typedef struct packed {
        logic [SLOT_W-1:0]   shreg;
        logic [CNT_W-1:0]    cnt;
        logic                lr_prev;
        logic [SAMPLE_W-1:0] left_hold;
        logic [SAMPLE_W-1:0] left_out;
        logic [SAMPLE_W-1:0] right_out;
        logic                valid;
    } rx_st_t;

    fmt_e                fmt;
    logic [3:0]          sync_lvl, sync_rise;
    logic                mck_rise_w, bck_rise_w, lr_rise_w, lr_s, sd_s;
    logic [SLOT_W-1:0]   shifted, done_word;
    logic [CNT_W-1:0]    cnt_inc, done_cnt;
    logic                lr_edge, is_left;
    logic [SAMPLE_W-1:0] aligned;
    rx_st_t              st_d, st_q;

    assign fmt = fmt_e'(fmt_sel);

    serial_audio_rx_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({mck, bck, lrck, sdin}),
        .dout (sync_lvl),
        .rise (sync_rise)
    );

    assign mck_rise_w = sync_rise[3];
    assign bck_rise_w = sync_rise[2];
    assign lr_rise_w  = sync_rise[1];
    assign lr_s       = sync_lvl[1];
    assign sd_s       = sync_lvl[0];

    serial_audio_rx_ratio #(.CNT_W(RATIO_CNT_W)) ratio_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mck_rise  (mck_rise_w),
        .frame_rise(lr_rise_w),
        .ratio_ok  (ratio_ok)
    );

    // Word boundary: I2S counts the bit under the edge into the old word
    always_comb begin
        shifted = {st_q.shreg[SLOT_W-2:0], sd_s};
        cnt_inc = (st_q.cnt == CNT_W'(SLOT_W)) ? st_q.cnt : st_q.cnt + 1'b1;
        lr_edge = bck_rise_w && (lr_s != st_q.lr_prev);
        is_left = (fmt == FMT_I2S) ? !st_q.lr_prev : st_q.lr_prev;
        if (fmt == FMT_I2S) begin
            done_word = shifted;
            done_cnt  = cnt_inc;
        end else begin
            done_word = st_q.shreg;
            done_cnt  = st_q.cnt;
        end
    end

    serial_audio_rx_align #(.SLOT_W(SLOT_W), .SAMPLE_W(SAMPLE_W)) align_i (
        .fmt   (fmt),
        .word  (done_word),
        .nbits (done_cnt),
        .sample(aligned)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (bck_rise_w) begin
            st_d.lr_prev = lr_s;
            if (lr_edge) begin
                if (fmt == FMT_I2S) begin
                    st_d.shreg = '0;
                    st_d.cnt   = '0;
                end else begin
                    st_d.shreg = {{(SLOT_W-1){1'b0}}, sd_s};
                    st_d.cnt   = CNT_W'(1);
                end
                if (is_left) begin
                    st_d.left_hold = aligned;
                end else begin
                    st_d.left_out  = st_q.left_hold;
                    st_d.right_out = aligned;
                    st_d.valid     = 1'b1;
                end
            end else begin
                st_d.shreg = shifted;
                st_d.cnt   = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign left_sample  = st_q.left_out;
    assign right_sample = st_q.right_out;
    assign sample_valid = st_q.valid;
endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk #(
    parameter int SAMPLE_W = 24
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2:0]          fmt_sel,
    input logic [SAMPLE_W-1:0] left_sample,
    input logic [SAMPLE_W-1:0] right_sample,
    input logic                sample_valid,
    input logic                ratio_ok,
    input logic                bck_rise,
    input logic                lr_rise
);
    p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    p_valid_after_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> $past(bck_rise));

    p_hold_between_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |-> ($stable(left_sample) && $stable(right_sample)));

    p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && fmt_sel == 3'd7) |-> (left_sample == '0 && right_sample == '0));

    p_ratio_on_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ratio_ok) |-> $past(lr_rise));
endmodule

bind serial_audio_rx serial_audio_rx_chk #(.SAMPLE_W(SAMPLE_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .fmt_sel     (fmt_sel),
    .left_sample (left_sample),
    .right_sample(right_sample),
    .sample_valid(sample_valid),
    .ratio_ok    (ratio_ok),
    .bck_rise    (bck_rise_w),
    .lr_rise     (lr_rise_w)
);

// File: tb/serial_audio_rx_tb_top.sv
`timescale 1ns/1ps
module serial_audio_rx_tb_top;
    localparam int BCK_PER = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  fmt_sel = 3'd0;
    logic        mck = 1'b0, bck = 1'b0, lrck = 1'b0, sdin = 1'b0;
    logic [23:0] left_sample, right_sample;
    logic        sample_valid, ratio_ok;

    int          n_checks = 0, n_fail = 0, cyc = 0;
    int          mper = 6;
    int          gtick = 0;
    logic        carry = 1'b0;
    logic [47:0] exp_q[$];
    logic [23:0] prev_l = '0, prev_r = '0, last_l = '0, last_r = '0;

    always #2.5 clk = ~clk;

    serial_audio_rx dut_i (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .mck(mck), .bck(bck),
        .lrck(lrck), .sdin(sdin), .left_sample(left_sample),
        .right_sample(right_sample), .sample_valid(sample_valid), .ratio_ok(ratio_ok)
    );

    function automatic string fmt_tag(input logic [2:0] f);
        case (f)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R5";
            3'd7: return "R6";
            default: return "R4";
        endcase
    endfunction

    function automatic logic [23:0] rev24(input logic [23:0] v);
        logic [23:0] r;
        for (int i = 0; i < 24; i++) r[i] = v[23-i];
        return r;
    endfunction

    function automatic int rj_bits(input logic [2:0] f);
        case (f)
            3'd3: return 16;
            3'd4: return 18;
            3'd5: return 20;
            default: return 24;
        endcase
    endfunction

    // Bit pattern for one 32-bit slot, MSB of pattern sent first
    function automatic logic [31:0] make_pat(input logic [2:0] f, input logic [23:0] s,
                                             input logic [31:0] junk);
        logic [31:0] mask;
        case (f)
            3'd0, 3'd1: return {s, junk[7:0]};
            3'd2:       return {junk[31:24], rev24(s)};
            3'd7:       return junk;
            default: begin
                mask = (32'd1 << rj_bits(f)) - 32'd1;
                return (junk & ~mask) | ({8'd0, s} & mask);
            end
        endcase
    endfunction

    function automatic logic [23:0] make_exp(input logic [2:0] f, input logic [23:0] s);
        logic [23:0] mask;
        case (f)
            3'd0, 3'd1, 3'd2, 3'd6: return s;
            3'd7: return '0;
            default: begin
                mask = (24'd1 << rj_bits(f)) - 24'd1;
                return (s & mask) << (24 - rj_bits(f));
            end
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [47:0] act, input logic [47:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        mck = ((gtick % mper) < (mper / 2));
        gtick++;
    endtask

    task automatic send_slot(input logic lvl, input logic [31:0] pat);
        for (int i = 0; i < 32; i++) begin
            for (int t = 0; t < BCK_PER; t++) begin
                tick();
                if (t == 0) begin
                    bck  = 1'b0;
                    lrck = lvl;
                    if (fmt_sel == 3'd0) sdin = (i == 0) ? carry : pat[32-i];
                    else                 sdin = pat[31-i];
                end
                if (t == BCK_PER / 2) bck = 1'b1;
            end
        end
        carry = pat[0];
    endtask

    // Monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && sample_valid) begin
            logic [47:0] e;
            check(prev_l == last_l && prev_r == last_r, "R9", "hold before strobe",
                  {prev_l, prev_r}, {last_l, last_r});
            if (exp_q.size() == 0) begin
                check(1'b0, "R7", "unexpected strobe", {left_sample, right_sample}, '0);
            end else begin
                e = exp_q.pop_front();
                check({left_sample, right_sample} == e, fmt_tag(fmt_sel), "stereo pair",
                      {left_sample, right_sample}, e);
            end
            last_l = left_sample;
            last_r = right_sample;
        end
        prev_l = left_sample;
        prev_r = right_sample;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R7 actual=%0d expected=<190000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    task automatic run(input logic [2:0] f, input int mp, input int nfr, input bit ok_exp);
        logic        left_lvl;
        logic [23:0] ls, rs;
        rst_n = 1'b0;
        fmt_sel = f;
        mper = mp;
        carry = 1'b0;
        left_lvl = (f == 3'd0) ? 1'b0 : 1'b1;
        bck = 1'b0;
        lrck = ~left_lvl;
        sdin = 1'b0;
        repeat (6) tick();
        check(left_sample == '0 && right_sample == '0 && !sample_valid && !ratio_ok,
              "R1", "reset state", {left_sample, right_sample},
              '0);
        rst_n = 1'b1;
        last_l = '0;
        last_r = '0;
        exp_q.push_back('0);
        send_slot(~left_lvl, 32'd0);
        for (int fr = 0; fr < nfr; fr++) begin
            case (fr)
                0: begin ls = 24'h800000; rs = 24'h7FFFFF; end
                1: begin ls = 24'hFFFFFF; rs = 24'h000001; end
                default: begin ls = 24'($urandom()); rs = 24'($urandom()); end
            endcase
            exp_q.push_back({make_exp(f, ls), make_exp(f, rs)});
            send_slot(left_lvl, make_pat(f, ls, $urandom()));
            send_slot(~left_lvl, make_pat(f, rs, $urandom()));
        end
        send_slot(left_lvl, 32'd0);
        repeat (10) tick();
        check(exp_q.size() == 0, "R7", "all frames strobed", 48'(exp_q.size()), '0);
        exp_q.delete();
        check(ratio_ok == ok_exp, "R8", "mck ratio flag", 48'(ratio_ok), 48'(ok_exp));
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        run(3'd0, 6, 5, 1'b1);
        run(3'd1, 4, 5, 1'b1);
        run(3'd2, 3, 5, 1'b1);
        run(3'd3, 2, 5, 1'b1);
        run(3'd4, 8, 5, 1'b0);
        run(3'd5, 6, 5, 1'b1);
        run(3'd6, 4, 5, 1'b1);
        run(3'd7, 8, 5, 1'b0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule